// File: doc/BRIEF.md
# Output-Compare Interrupt Timer

This block is a free-running 16-bit timer with eight compare channels, driven through a small register bus. A power-of-two prescaler sets the counter's rate, and a single run bit starts or stops counting. Each channel holds a compare value. When a channel is in compare mode and the counter steps onto that value, the channel latches a service flag. A flag raises that channel's request line when its arm bit is also set. A global mask input can hold back the combined request line, but it never discards a flag.

Software services a channel by writing a one to the flag's bit position. To produce a periodic event, software then adds a fixed offset to the old compare value. Because the counter wraps, a target placed beyond 0xFFFF still matches once the count rolls over.

The tick generator is a two-state machine. TK_IDLE holds the prescaler at zero, and the transition TK_IDLE to TK_RUN happens on the edge after the run bit is seen set. TK_RUN counts prescaler cycles and issues a tick each time the low N bits of the prescaler are all ones. The transition TK_RUN to TK_IDLE happens once the run bit is seen clear. No tick is issued in TK_RUN while the run bit is already clear.

Top module: `cmp_timer`

## Requirements
- R1: The counter (read at address 5) advances by one per tick, and only while the run bit (bit 7 at address 0) is set. After a write that sets the run bit and a write that clears it K+1 clock edges later, with a prescale of 0, the count has risen by exactly K. While the run bit is clear, the count holds.
- R2: The prescale field (bits 2:0 at address 1) holds N. The counter then advances once every 2^N clocks, so a run window as in R1 adds floor(K / 2^N) counts.
- R3: On the edge where the counter steps onto the value in the compare register of channel i (address 8+i), flag i (bit i at address 4) becomes one, provided mode bit i (address 2) is one.
- R4: A channel whose mode bit is zero never sets its flag from a compare.
- R5: irq_req[i] is one exactly when flag i and arm bit i (address 3) are both one.
- R6: irq_any is the OR of irq_req while irq_mask is low, and zero while irq_mask is high. Raising the mask changes no flag, so the request returns when the mask drops.
- R7: Writing address 4 clears each flag whose data bit is one. Flags whose data bit is zero keep their value.
- R8: The counter wraps from 0xFFFF to 0x0000, and a compare value reached only after the roll-over still sets its flag.
- R9: When a compare sets a flag on the same edge that a write-one-to-clear targets it, the flag stays one.
- R10: Reads return the run bit, prescale, mode and arm values last written. Compare registers return the last value written to them. Address 5 returns the live count and ignores writes. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe, sampled on the rising edge |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq_mask | input | 1 | Global mask; high holds irq_any low |
| irq_req | output | 8 | Per-channel request, flag AND arm |
| irq_any | output | 1 | Combined request, gated by irq_mask |

## Verification
A compare match and a software acknowledge can land on the same edge. The bench provokes this by reading the stopped count and setting a channel's compare value three counts ahead. It then starts the counter and issues the write-one-to-clear on exactly the edge where the counter reaches that value, which it finds by counting edges from the run-bit write. Afterwards it stops the counter and reads the flag back: the flag must still be one. It then clears the flag with no match present and confirms that the clear takes effect.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    typedef enum logic [0:0] {
        TK_IDLE = 1'b0,
        TK_RUN  = 1'b1
    } tick_state_e;

    localparam int A_CTRL     = 0;
    localparam int A_PRESC    = 1;
    localparam int A_MODE     = 2;
    localparam int A_ARM      = 3;
    localparam int A_FLAG     = 4;
    localparam int A_COUNT    = 5;
    localparam int A_CMP_BASE = 8;

    localparam int RUN_BIT    = 7;

endpackage

// File: rtl/cmp_timer_tick.sv
module cmp_timer_tick
    import cmp_timer_pkg::*;
#(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_en,
    input  logic [PS_W-1:0] ps_sel,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    tick_state_e      state_q, state_d;
    logic [DIV_W-1:0] prediv_q;
    logic [DIV_W-1:0] pmask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TK_IDLE: state_d = run_en ? TK_RUN  : TK_IDLE;
            TK_RUN:  state_d = run_en ? TK_RUN  : TK_IDLE;
            default: state_d = TK_IDLE;
        endcase
    end

    assign pmask = ~({DIV_W{1'b1}} << ps_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          prediv_q <= '0;
        else if (state_q == TK_RUN && run_en) prediv_q <= prediv_q + 1'b1;
        else                                 prediv_q <= '0;
    end

    always_comb begin
        tick = 1'b0;
        unique case (state_q)
            TK_RUN:  tick = run_en && ((prediv_q & pmask) == pmask);
            default: tick = 1'b0;
        endcase
    end

    // R2: with a nonzero, unchanged prescale two ticks never fall back to back
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ps_sel != '0) |=> (!tick || ps_sel != $past(ps_sel)));

endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);
    assign cnt_nxt = cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= cnt_nxt;
    end

    // R1: without a tick the count holds
    assert_hold_without_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

    // R8: the all-ones count rolls over to zero
    assert_wrap_to_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == {CNT_W{1'b1}}) |=> (cnt_q == '0));

endmodule

// File: rtl/cmp_timer_chan.sv
module cmp_timer_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             oc_en,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wd,
    input  logic             clr,
    output logic [CNT_W-1:0] cmp_q,
    output logic             flag_q
);
    logic hit;

    assign hit = tick && oc_en && (cnt_nxt == cmp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_we) cmp_q <= cmp_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (hit) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    // R3: a flag only rises on a counter step
    assert_flag_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick));

    // R4: a channel outside compare mode never raises its flag
    assert_no_set_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !oc_en |=> !$rose(flag_q));

    // R7: a set flag persists until cleared, whatever the mask does
    assert_flag_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);

    // R9: a match beats a simultaneous clear
    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && oc_en && cnt_nxt == cmp_q && clr) |=> flag_q);

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_CH  = 8,
    parameter int PS_W  = 3,
    parameter int AW    = 4,
    parameter int DW    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic            reg_wr,
    output logic [DW-1:0]   reg_rdata,
    input  logic            irq_mask,
    output logic [N_CH-1:0] irq_req,
    output logic            irq_any
);
    localparam logic [AW-1:0] AD_CTRL  = AW'(A_CTRL);
    localparam logic [AW-1:0] AD_PRESC = AW'(A_PRESC);
    localparam logic [AW-1:0] AD_MODE  = AW'(A_MODE);
    localparam logic [AW-1:0] AD_ARM   = AW'(A_ARM);
    localparam logic [AW-1:0] AD_FLAG  = AW'(A_FLAG);
    localparam logic [AW-1:0] AD_COUNT = AW'(A_COUNT);

    logic            run_q;
    logic [PS_W-1:0] ps_q;
    logic [N_CH-1:0] oc_q;
    logic [N_CH-1:0] arm_q;
    logic [N_CH-1:0] flag_vec;
    logic [N_CH-1:0] clr_vec;
    logic            tick;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] cmp_arr [N_CH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ps_q  <= '0;
            oc_q  <= '0;
            arm_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == AD_CTRL)  run_q <= reg_wdata[RUN_BIT];
            if (reg_addr == AD_PRESC) ps_q  <= reg_wdata[PS_W-1:0];
            if (reg_addr == AD_MODE)  oc_q  <= reg_wdata[N_CH-1:0];
            if (reg_addr == AD_ARM)   arm_q <= reg_wdata[N_CH-1:0];
        end
    end

    assign clr_vec = (reg_wr && reg_addr == AD_FLAG) ? reg_wdata[N_CH-1:0] : '0;

    cmp_timer_tick #(.PS_W(PS_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_en (run_q),
        .ps_sel (ps_q),
        .tick   (tick)
    );

    cmp_timer_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_chan
        logic cmp_we;
        assign cmp_we = reg_wr && (reg_addr == AW'(A_CMP_BASE + i));

        cmp_timer_chan #(.CNT_W(CNT_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .cnt_nxt (cnt_nxt),
            .oc_en   (oc_q[i]),
            .cmp_we  (cmp_we),
            .cmp_wd  (reg_wdata[CNT_W-1:0]),
            .clr     (clr_vec[i]),
            .cmp_q   (cmp_arr[i]),
            .flag_q  (flag_vec[i])
        );
    end

    assign irq_req = flag_vec & arm_q;
    assign irq_any = !irq_mask && (|irq_req);

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AD_CTRL:  reg_rdata[RUN_BIT]    = run_q;
            AD_PRESC: reg_rdata[PS_W-1:0]   = ps_q;
            AD_MODE:  reg_rdata[N_CH-1:0]   = oc_q;
            AD_ARM:   reg_rdata[N_CH-1:0]   = arm_q;
            AD_FLAG:  reg_rdata[N_CH-1:0]   = flag_vec;
            AD_COUNT: reg_rdata[CNT_W-1:0]  = cnt_q;
            default: begin
                for (int k = 0; k < N_CH; k++) begin
                    if (reg_addr == AW'(A_CMP_BASE + k))
                        reg_rdata[CNT_W-1:0] = cmp_arr[k];
                end
            end
        endcase
    end

    // R6: a raised mask leaves every flag as it was on the next edge unless written
    assert_mask_keeps_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask && !(reg_wr && reg_addr == AD_FLAG)) |=> ((flag_vec & $past(flag_vec)) == $past(flag_vec)));

    // R5: a request line never stays up once its arm bit has been cleared
    assert_req_follows_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AD_ARM && reg_wdata[N_CH-1:0] == '0) |=> (irq_req == '0));

endmodule

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam int NV = 19;
    localparam logic [21:0] VEC [NV] = '{
        {OP_WR, 4'h1, 16'h0005}, {OP_RD, 4'h1, 16'h0005},
        {OP_WR, 4'h2, 16'h00F7}, {OP_RD, 4'h2, 16'h00F7},
        {OP_WR, 4'h3, 16'h0011}, {OP_RD, 4'h3, 16'h0011},
        {OP_WR, 4'h8, 16'h0005}, {OP_RD, 4'h8, 16'h0005},
        {OP_WR, 4'hF, 16'hBEEF}, {OP_RD, 4'hF, 16'hBEEF},
        {OP_WR, 4'hB, 16'h0002}, {OP_RD, 4'hB, 16'h0002},
        {OP_WR, 4'h5, 16'h1234}, {OP_RD, 4'h5, 16'h0000},
        {OP_RD, 4'h6, 16'h0000}, {OP_WR, 4'h1, 16'h0000},
        {OP_RD, 4'h1, 16'h0000}, {OP_RD, 4'h4, 16'h0000},
        {OP_RD, 4'h0, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_rdata;
    logic        irq_mask = 1'b0;
    logic [7:0]  irq_req;
    logic        irq_any;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] rv;
    logic [15:0] c0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rdata (reg_rdata),
        .irq_mask  (irq_mask),
        .irq_req   (irq_req),
        .irq_any   (irq_any)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic run_for(input int k);
        wr(4'h0, 16'h0080);
        repeat (k) @(negedge clk);
        wr(4'h0, 16'h0000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state (R10, R5, R6)
        rd(4'h5, rv); chk("R10 reset count", rv, 16'h0000);
        rd(4'h4, rv); chk("R10 reset flags", rv, 16'h0000);
        chk("R5 reset irq_req", {8'h00, irq_req}, 16'h0000);
        chk("R6 reset irq_any", {15'h0, irq_any}, 16'h0000);

        // register table (R10)
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][21:20] == OP_WR) wr(VEC[v][19:16], VEC[v][15:0]);
            else begin
                rd(VEC[v][19:16], rv);
                chk("R10 table read", rv, VEC[v][15:0]);
            end
        end
        wr(4'h0, 16'h0080);
        rd(4'h0, rv); chk("R10 run bit read", rv, 16'h0080);
        wr(4'h0, 16'h0000);
        rd(4'h5, c0);

        // run window, prescale 0 (R1), compare hits (R3), off channel (R4)
        run_for(10);
        rd(4'h5, rv); chk("R1 count after run", rv, c0 + 16'd10);
        repeat (5) @(negedge clk);
        rd(4'h5, rv); chk("R1 count holds when stopped", rv, c0 + 16'd10);
        rd(4'h4, rv); chk("R3 R4 flags after run", rv, 16'h0001);

        // request and mask (R5, R6)
        chk("R5 irq_req", {8'h00, irq_req}, 16'h0001);
        chk("R6 irq_any unmasked", {15'h0, irq_any}, 16'h0001);
        irq_mask = 1'b1; @(negedge clk);
        chk("R6 irq_any masked", {15'h0, irq_any}, 16'h0000);
        rd(4'h4, rv); chk("R6 flag kept while masked", rv, 16'h0001);
        irq_mask = 1'b0; @(negedge clk);
        chk("R6 irq_any after unmask", {15'h0, irq_any}, 16'h0001);

        // write-one-to-clear (R7)
        wr(4'h4, 16'h00FE);
        rd(4'h4, rv); chk("R7 zero bits keep flag", rv, 16'h0001);
        wr(4'h4, 16'h0001);
        rd(4'h4, rv); chk("R7 one bit clears flag", rv, 16'h0000);
        chk("R5 irq_any after clear", {15'h0, irq_any}, 16'h0000);

        // prescale (R2)
        rd(4'h5, c0);
        wr(4'h1, 16'h0003);
        run_for(20);
        rd(4'h5, rv); chk("R2 prescale 3", rv, c0 + 16'd2);
        wr(4'h1, 16'h0002);
        run_for(9);
        rd(4'h5, rv); chk("R2 prescale 2", rv, c0 + 16'd4);
        wr(4'h1, 16'h0000);

        // same-edge match and clear (R9)
        rd(4'h5, c0);
        wr(4'hC, c0 + 16'd3);
        wr(4'h4, 16'h00FF);
        wr(4'h0, 16'h0080);
        repeat (3) @(negedge clk);
        wr(4'h4, 16'h0010);
        wr(4'h0, 16'h0000);
        rd(4'h4, rv); chk("R9 set wins over clear", rv & 16'h0010, 16'h0010);
        rd(4'h5, rv); chk("R1 count after short run", rv, c0 + 16'd4);
        wr(4'h4, 16'h0010);
        rd(4'h4, rv); chk("R7 clear without match", rv & 16'h0010, 16'h0000);

        // wrap (R8)
        rd(4'h5, c0);
        wr(4'hA, 16'h0003);
        wr(4'h4, 16'h00FF);
        run_for(65536 + 5);
        rd(4'h5, rv); chk("R8 count after wrap", rv, c0 + 16'd5);
        rd(4'h4, rv); chk("R8 R4 flags after wrap", rv, 16'h00F7);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule